// File: doc/BRIEF.md
# Write-Command Sequencer with Single-Pulse Program Mode

This block sits between a host write port and a flash programming engine. It watches each host write cycle (a one-clock write strobe with address and data) and decides whether that write is part of a command prefix or a piece of data to program. In normal operation, a location is programmed only after three prefix writes with fixed address/data pairs. The fourth write then issues a program request that carries its own address and data.

A separate six-write entry sequence switches the block into a fast mode. In fast mode every accepted write becomes a program request straight away, even one that looks like a command. Fast mode ends only on the synchronous system reset (power-up) or when the external active-low reset pin has been held low for a minimum number of clock cycles and then released. A shorter low pulse leaves the mode as it was. A write that arrives while the programming engine reports busy is dropped, and a sticky error flag is raised.

Top module: `spm_cmd_seq`

## Requirements
- R1: After `rst` is high at a clock edge, `fast_mode`, `prog_req` and `busy_err` are all 0, and the prefix decoder is idle.
- R2: In normal mode, three accepted writes matching the prefix pairs (default 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, in that order) followed by any accepted write make `prog_req` high for exactly one cycle. It rises in the cycle after that fourth write's clock edge, with `prog_addr`/`prog_data` equal to that write's address and data. Once the prefix is complete, this takes priority over any entry-sequence match.
- R3: In normal mode, an accepted write that continues neither the program prefix nor the entry sequence returns the decoder to idle and produces no program request. Only writes that arrive later can start a new match.
- R4: Six accepted writes matching the entry pairs in order (default 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0xC0) set `fast_mode` in the cycle after the sixth write. The sixth write is not programmed.
- R5: In fast mode, each accepted write makes `prog_req` high for one cycle in the cycle after its edge, carrying that write's address and data.
- R6: In fast mode, writes that match the program prefix or the entry sequence are programmed as plain data, and they do not change `fast_mode`.
- R7: When `hw_rst_n` has been sampled low on at least `MIN_LOW_CYC` consecutive edges and is then sampled high, `fast_mode` is 0 from the cycle after that first high sample.
- R8: A low pulse on `hw_rst_n` of fewer than `MIN_LOW_CYC` samples leaves `fast_mode` unchanged.
- R9: Writes sampled while `hw_rst_n` is low are ignored (no request, no error), and any low sample returns the decoder to idle.
- R10: A write sampled while `prog_busy` is high produces no request and does not advance or reset the decoder. It sets `busy_err`, which stays 1 until `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| hw_rst_n | input | 1 | External active-low reset pin, already synchronous to clk |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | DW | Host write data |
| prog_busy | input | 1 | Programming engine busy |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | AW | Address to program |
| prog_data | output | DW | Data to program |
| fast_mode | output | 1 | Single-pulse program mode active |
| busy_err | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The bench builds the block with `MIN_LOW_CYC` set to 8 and keeps the default widths and sequence pairs. This puts low pulses of exactly the threshold and one cycle short of it within a few cycles, so both sides of the boundary in R7 and R8 are covered several times. The default sequences share their first two pairs, which means a single write stream exercises the program prefix, the entry sequence, the point where they split, and the prefix-completion priority. A queue-based reference model predicts the request, address, data, mode and error outputs, and they are compared on every clock.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int PFX_LEN   = 3;
    localparam int ENTRY_LEN = 6;
    localparam int POS_W     = $clog2(ENTRY_LEN + 1);

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ADVANCE,
        ACT_PROGRAM,
        ACT_ENTER,
        ACT_RESTART
    } dec_act_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             cand_pfx;
        logic             cand_ent;
    } dec_state_t;

    function automatic dec_state_t idle_state();
        dec_state_t s;
        s.pos      = '0;
        s.cand_pfx = 1'b1;
        s.cand_ent = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/spm_low_timer.sv
module spm_low_timer #(
    parameter int MIN_LOW_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic long_release
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW_CYC);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!pin_n) begin
            if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign long_release = pin_n && (low_cnt == LIMIT);

    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LIMIT);
    a_r7_cnt_clears_high: assert property (@(posedge clk) disable iff (rst)
        pin_n |=> low_cnt == '0);

endmodule

// File: rtl/spm_prefix_dec.sv
module spm_prefix_dec
    import spm_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16,
    parameter logic [PFX_LEN*AW-1:0]   PFX_ADDR = '0,
    parameter logic [PFX_LEN*DW-1:0]   PFX_DATA = '0,
    parameter logic [ENTRY_LEN*AW-1:0] ENT_ADDR = '0,
    parameter logic [ENTRY_LEN*DW-1:0] ENT_DATA = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_idle,
    input  logic          fire,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          prog_hit,
    output logic          enter_hit
);
    dec_state_t st, st_nx;
    dec_act_e   act;
    logic [AW-1:0] pfx_a_v [PFX_LEN];
    logic [DW-1:0] pfx_d_v [PFX_LEN];
    logic [AW-1:0] ent_a_v [ENTRY_LEN];
    logic [DW-1:0] ent_d_v [ENTRY_LEN];
    logic pfx_match, ent_match, pfx_done, ent_last;
    logic [POS_W-1:0] pfx_idx;

    for (genvar i = 0; i < PFX_LEN; i++) begin : g_pfx
        assign pfx_a_v[i] = PFX_ADDR[i*AW +: AW];
        assign pfx_d_v[i] = PFX_DATA[i*DW +: DW];
    end
    for (genvar j = 0; j < ENTRY_LEN; j++) begin : g_ent
        assign ent_a_v[j] = ENT_ADDR[j*AW +: AW];
        assign ent_d_v[j] = ENT_DATA[j*DW +: DW];
    end

    always_comb begin
        pfx_idx   = (st.pos < POS_W'(PFX_LEN)) ? st.pos : '0;
        pfx_done  = st.cand_pfx && (st.pos == POS_W'(PFX_LEN));
        pfx_match = st.cand_pfx && (st.pos < POS_W'(PFX_LEN)) &&
                    (addr == pfx_a_v[pfx_idx]) && (data == pfx_d_v[pfx_idx]);
        ent_match = st.cand_ent && (st.pos < POS_W'(ENTRY_LEN)) &&
                    (addr == ent_a_v[st.pos]) && (data == ent_d_v[st.pos]);
        ent_last  = ent_match && (st.pos == POS_W'(ENTRY_LEN - 1));
        if (!fire)                      act = ACT_NONE;
        else if (pfx_done)              act = ACT_PROGRAM;
        else if (ent_last)              act = ACT_ENTER;
        else if (pfx_match || ent_match) act = ACT_ADVANCE;
        else                            act = ACT_RESTART;
    end

    always_comb begin
        st_nx = st;
        unique case (act)
            ACT_ADVANCE: begin
                st_nx.pos      = st.pos + 1'b1;
                st_nx.cand_pfx = pfx_match;
                st_nx.cand_ent = ent_match;
            end
            ACT_PROGRAM, ACT_ENTER, ACT_RESTART: st_nx = idle_state();
            default: st_nx = st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || hold_idle) st <= idle_state();
        else                  st <= st_nx;
    end

    assign prog_hit  = !hold_idle && (act == ACT_PROGRAM);
    assign enter_hit = !hold_idle && (act == ACT_ENTER);

    a_r3_pos_bounded: assert property (@(posedge clk) disable iff (rst)
        st.pos < POS_W'(ENTRY_LEN));
    a_r3_some_candidate: assert property (@(posedge clk) disable iff (rst)
        st.cand_pfx || st.cand_ent);
    a_r2_hits_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_hit, enter_hit}));
    a_r9_idle_after_hold: assert property (@(posedge clk) disable iff (rst)
        hold_idle |=> st.pos == '0);

endmodule

// File: rtl/spm_req_stage.sv
module spm_req_stage #(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          req,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
        end else begin
            req <= issue;
            if (issue) begin
                req_addr <= addr;
                req_data <= data;
            end
        end
    end

    a_r5_payload_held: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(req_addr) && $stable(req_data));

endmodule

// File: rtl/spm_cmd_seq.sv
module spm_cmd_seq
    import spm_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16,
    parameter int MIN_LOW_CYC = 100,
    parameter logic [PFX_LEN*AW-1:0] PFX_ADDR =
        {AW'(21'h555), AW'(21'h2AA), AW'(21'h555)},
    parameter logic [PFX_LEN*DW-1:0] PFX_DATA =
        {DW'(16'h00A0), DW'(16'h0055), DW'(16'h00AA)},
    parameter logic [ENTRY_LEN*AW-1:0] ENT_ADDR =
        {AW'(21'h555), AW'(21'h2AA), AW'(21'h555),
         AW'(21'h555), AW'(21'h2AA), AW'(21'h555)},
    parameter logic [ENTRY_LEN*DW-1:0] ENT_DATA =
        {DW'(16'h00C0), DW'(16'h0055), DW'(16'h00AA),
         DW'(16'h0080), DW'(16'h0055), DW'(16'h00AA)}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          prog_busy,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          fast_mode,
    output logic          busy_err
);
    logic accepted, dropped, long_release, prog_hit, enter_hit, issue;

    assign accepted = wr_en && hw_rst_n && !prog_busy;
    assign dropped  = wr_en && hw_rst_n && prog_busy;

    spm_low_timer #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .pin_n        (hw_rst_n),
        .long_release (long_release)
    );

    spm_prefix_dec #(
        .AW(AW), .DW(DW),
        .PFX_ADDR(PFX_ADDR), .PFX_DATA(PFX_DATA),
        .ENT_ADDR(ENT_ADDR), .ENT_DATA(ENT_DATA)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .hold_idle (fast_mode || !hw_rst_n),
        .fire      (accepted),
        .addr      (wr_addr),
        .data      (wr_data),
        .prog_hit  (prog_hit),
        .enter_hit (enter_hit)
    );

    assign issue = accepted && (fast_mode || prog_hit);

    spm_req_stage #(.AW(AW), .DW(DW)) u_req (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .addr     (wr_addr),
        .data     (wr_data),
        .req      (prog_req),
        .req_addr (prog_addr),
        .req_data (prog_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_mode <= 1'b0;
            busy_err  <= 1'b0;
        end else begin
            if (long_release)   fast_mode <= 1'b0;
            else if (enter_hit) fast_mode <= 1'b1;
            if (dropped) busy_err <= 1'b1;
        end
    end

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        busy_err |=> busy_err);
    a_r10_busy_no_req: assert property (@(posedge clk) disable iff (rst)
        (wr_en && prog_busy) |=> !prog_req);
    a_r9_low_no_req: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hw_rst_n) |=> !prog_req);
    a_r5_req_from_write: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> $past(wr_en));
    a_r5_fast_programs: assert property (@(posedge clk) disable iff (rst)
        (fast_mode && wr_en && hw_rst_n && !prog_busy) |=>
            prog_req && prog_addr == $past(wr_addr) && prog_data == $past(wr_data));
    a_r8_low_keeps_fast: assert property (@(posedge clk) disable iff (rst)
        (fast_mode && !hw_rst_n) |=> fast_mode);
    a_r7_exit_on_high: assert property (@(posedge clk) disable iff (rst)
        $fell(fast_mode) |-> $past(hw_rst_n));
    a_r4_enter_no_req: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_mode) |-> !prog_req);

endmodule

// File: tb/tb_spm_cmd_seq.sv
`timescale 1ns/1ps
module tb_spm_cmd_seq;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int MINL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hw_rst_n = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic prog_busy = 1'b0;
    logic prog_req, fast_mode, busy_err;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    always #2.5 clk = ~clk;

    spm_cmd_seq #(.AW(AW), .DW(DW), .MIN_LOW_CYC(MINL)) dut (
        .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_busy(prog_busy),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .fast_mode(fast_mode), .busy_err(busy_err)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference sequences, index 0 first
    int pa [3] = '{'h555, 'h2AA, 'h555};
    int pd [3] = '{'hAA, 'h55, 'hA0};
    int ea [6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 'h555};
    int ed [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'hC0};

    // behavioural model
    int hist_a [$];
    int hist_d [$];
    int low_run = 0;
    bit m_fast = 0, m_err = 0, m_req = 0;
    int m_addr = 0, m_data = 0;

    function automatic bit is_prefix_of(input bit use_entry);
        int n = hist_a.size();
        if (use_entry ? n > 6 : n > 3) return 0;
        for (int k = 0; k < n; k++) begin
            if (use_entry) begin
                if (hist_a[k] != ea[k] || hist_d[k] != ed[k]) return 0;
            end else begin
                if (hist_a[k] != pa[k] || hist_d[k] != pd[k]) return 0;
            end
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        m_req = 0;
        if (rst) begin
            m_fast = 0; m_err = 0; low_run = 0;
            hist_a.delete(); hist_d.delete();
        end else if (!hw_rst_n) begin
            low_run++;
            hist_a.delete(); hist_d.delete();
        end else begin
            if (low_run >= MINL) m_fast = 0;
            low_run = 0;
            if (wr_en && prog_busy) m_err = 1;
            else if (wr_en) begin
                if (m_fast) begin
                    m_req = 1; m_addr = int'(wr_addr); m_data = int'(wr_data);
                end else if (hist_a.size() == 3 && is_prefix_of(0)) begin
                    m_req = 1; m_addr = int'(wr_addr); m_data = int'(wr_data);
                    hist_a.delete(); hist_d.delete();
                end else begin
                    hist_a.push_back(int'(wr_addr));
                    hist_d.push_back(int'(wr_data));
                    if (hist_a.size() == 6 && is_prefix_of(1)) begin
                        m_fast = 1;
                        hist_a.delete(); hist_d.delete();
                    end else if (!is_prefix_of(0) && !is_prefix_of(1)) begin
                        hist_a.delete(); hist_d.delete();
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(prog_req == m_req, "prog_req", int'(prog_req), int'(m_req));
            check(fast_mode == m_fast, "fast_mode", int'(fast_mode), int'(m_fast));
            check(busy_err == m_err, "busy_err", int'(busy_err), int'(m_err));
            if (m_req) begin
                check(int'(prog_addr) == m_addr, "prog_addr", int'(prog_addr), m_addr);
                check(int'(prog_data) == m_data, "prog_data", int'(prog_data), m_data);
            end
        end
    end

    task automatic wr(input int a, input int d, input bit busy = 0);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d); prog_busy = busy;
        @(negedge clk);
        wr_en = 0; prog_busy = 0;
    endtask

    task automatic prefix_then(input int a, input int d);
        for (int k = 0; k < 3; k++) wr(pa[k], pd[k]);
        wr(a, d);
    endtask

    task automatic entry_seq();
        for (int k = 0; k < 6; k++) wr(ea[k], ed[k]);
    endtask

    task automatic pin_low(input int n);
        @(negedge clk);
        hw_rst_n = 0;
        repeat (n) @(negedge clk);
        hw_rst_n = 1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk); rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        check(prog_req == 0 && fast_mode == 0 && busy_err == 0, "R1 reset outputs",
              {prog_req, fast_mode, busy_err}, 0);

        cur_req = "R2";
        prefix_then('h1234, 'hBEEF);
        @(negedge clk);
        prefix_then('h0042, 'h0001);
        @(negedge clk);
        check(fast_mode == 0, "R2 normal mode kept", int'(fast_mode), 0);

        cur_req = "R3";
        wr(pa[0], pd[0]); wr('h111, 'h22); wr('h300, 'h33);
        wr(pa[0], pd[0]); wr(pa[1], pd[1]); wr(pa[2], 'h99); wr('h301, 'h34);
        wr(ea[0], ed[0]); wr(ea[1], ed[1]); wr(ea[2], ed[2]); wr(ea[3], 'h00);
        wr('h555, 'hA0);
        prefix_then('h0777, 'h0AAA);

        cur_req = "R10";
        wr(pa[0], pd[0]); wr(pa[1], pd[1], 1);
        @(negedge clk);
        check(busy_err == 1, "R10 busy_err set", int'(busy_err), 1);
        wr(pa[1], pd[1]); wr(pa[2], pd[2]); wr('h0500, 'h5555);
        wr('h0600, 'h6666, 1);

        cur_req = "R9";
        wr(pa[0], pd[0]); wr(pa[1], pd[1]);
        pin_low(2);
        wr(pa[2], pd[2]); wr('h0701, 'h7171);
        @(negedge clk);
        hw_rst_n = 0; wr_en = 1; wr_addr = 'h10; wr_data = 'h10;
        @(negedge clk);
        wr_en = 0; hw_rst_n = 1;
        @(negedge clk);
        check(prog_req == 0, "R9 write during low ignored", int'(prog_req), 0);

        cur_req = "R4";
        entry_seq();
        @(negedge clk);
        check(fast_mode == 1, "R4 fast entered", int'(fast_mode), 1);

        cur_req = "R5";
        wr('h0100, 'h0011); wr('h0101, 'h0022); wr('h1FFFF, 'hFFFF);

        cur_req = "R6";
        prefix_then('h0200, 'h0033);
        entry_seq();
        check(fast_mode == 1, "R6 still fast", int'(fast_mode), 1);

        cur_req = "R8";
        pin_low(MINL - 1);
        @(negedge clk);
        check(fast_mode == 1, "R8 short pulse keeps fast", int'(fast_mode), 1);
        wr('h0300, 'h0044);
        pin_low(1);
        wr('h0301, 'h0045);

        cur_req = "R7";
        pin_low(MINL);
        @(negedge clk);
        check(fast_mode == 0, "R7 long pulse exits", int'(fast_mode), 0);
        wr('h0400, 'h0055);
        prefix_then('h0401, 'h0056);
        entry_seq();
        pin_low(MINL + 5);
        @(negedge clk);
        check(fast_mode == 0, "R7 longer pulse exits", int'(fast_mode), 0);

        cur_req = "R1";
        entry_seq();
        wr('h0, 'h0, 1);
        do_reset();
        @(negedge clk);
        check(fast_mode == 0 && busy_err == 0, "R1 reset clears mode and error",
              {fast_mode, busy_err}, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule